// File: doc/BRIEF.md
# Iterative Nested-Feistel Encryption Core

This block encrypts one 64-bit block under an 80-bit key for a small lightweight cipher. It iterates over rounds and spends area on registers rather than on combinational logic. The outer round is a four-branch Feistel permutation with no diffusion layer other than the branch rotation. The round function is itself a six-round Feistel network on 16 bits. Only one inner round is computed per clock, and the 16-bit intermediates stay in registers between cycles. Each outer round takes its 32-bit round key from an 80-bit key register that rotates in place.

A request starts with a single-cycle `start_i` while the core is idle. The plaintext and key are captured in that cycle. After a fixed 108 clock cycles the ciphertext appears on `ct_o` and `done_o` pulses for one cycle. `ct_o` then holds its value until the next request.

Top module: `nfeistel_enc`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0 and `ct_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is low captures `pt_i` and `key_i`, and `busy_o` is high in the following cycle.
- R3: `done_o` rises exactly 108 clock edges after the edge that accepted the request (18 outer rounds × 6 inner rounds, one inner round per edge).
- R4: `done_o` is high for exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R5: The state is four 16-bit branches with B0 = bits 63:48 down to B3 = bits 15:0. An outer round r with round key K = {KH, KL} computes N0=B0, N1=B1^F(B0)^KH, N2=B2 and N3=B3^F(B2)^KL. The new state is {N1,N2,N3,N0}.
- R6: F splits its 16-bit input into L = bits 15:8 and R = bits 7:0. Six times in a row it forms {L,R} ← {R, L ^ {S(R[7:4]), S(R[3:0])}}, and the final {L,R} is the output.
- R7: With the key register viewed as words W0 (bits 79:64) to W4 (bits 15:0), round r uses K = {W0,W1} XOR r, with r in 0..17 added into the low bits. After each round the register becomes {W2,W3,W4,W0,W1}.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running result and its timing are unchanged.
- R9: The final outer round (r = 17) does not rotate: the state becomes {N0,N1,N2,N3}.
- R10: While the core is idle and no start is given, `ct_o` keeps the last ciphertext.
- R11: S is the 4-bit table parameter. Its default, listed for inputs 0 to 15, is C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only while idle |
| pt_i | input | 64 | Plaintext block |
| key_i | input | 80 | Master key |
| ct_o | output | 64 | Ciphertext, valid when done_o pulses and held afterwards |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Encryption in progress |

## Verification
Assertions check the sequencing rules on every cycle. These are the one-cycle `done_o` pulse, `done_o` never overlapping `busy_o`, `busy_o` following an accepted start, and the inner counter staying in range. They also check that a running encryption cannot be cut short, that the key register captures the input key on a start, and that the output stays put while the core is idle. Only the bench's scenarios can show the arithmetic content. That covers the branch mixing, the inner Feistel with its S-box, the key rotation and round constant, and the unrotated last round. It also covers the exact 108-cycle latency and the immunity to a start that arrives mid-run. Each of these is observed as a ciphertext compared against an independent model.

// File: rtl/nf_pkg.sv
package nf_pkg;
  localparam int BLK_W  = 64;
  localparam int KEY_W  = 80;
  localparam int BR_W   = 16;
  localparam int HALF_W = BR_W / 2;
  localparam int NIB_W  = 4;
  localparam int RK_W   = 2 * BR_W;
  localparam int N_LANE = 2;

  localparam logic [63:0] SBOX_DEFAULT = 64'h21748FE3DA09B65C;
endpackage

// File: rtl/nf_inner_round.sv
module nf_inner_round
  import nf_pkg::*;
#(
  parameter logic [63:0] SBOX_TBL = SBOX_DEFAULT
) (
  input  logic [BR_W-1:0] x_i,
  output logic [BR_W-1:0] y_o
);
  localparam int N_NIB = HALF_W / NIB_W;

  logic [HALF_W-1:0] l_w, r_w, sub_w;

  assign l_w = x_i[BR_W-1:HALF_W];
  assign r_w = x_i[HALF_W-1:0];

  for (genvar g = 0; g < N_NIB; g++) begin : g_sbox
    logic [NIB_W-1:0] nib_w;
    assign nib_w = r_w[g*NIB_W +: NIB_W];
    assign sub_w[g*NIB_W +: NIB_W] = SBOX_TBL[{nib_w, 2'b00} +: NIB_W];
  end

  assign y_o = {r_w, l_w ^ sub_w};
endmodule

// File: rtl/nf_key_sched.sv
module nf_key_sched
  import nf_pkg::*;
#(
  parameter int RND_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             adv_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [RK_W-1:0]  rk_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (load_i) key_q <= key_i;
    else if (adv_i)  key_q <= {key_q[KEY_W-RK_W-1:0], key_q[KEY_W-1 -: RK_W]};
  end

  // two leading words plus round index constant
  assign rk_o = key_q[KEY_W-1 -: RK_W] ^ RK_W'(rnd_i);

  a_r7_key_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> key_q == $past(key_i));
endmodule

// File: rtl/nf_ctrl.sv
module nf_ctrl #(
  parameter int OUTER = 18,
  parameter int INNER = 6,
  localparam int IN_W  = $clog2(INNER + 1),
  localparam int RND_W = $clog2(OUTER + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             first_in_o,
  output logic             last_in_o,
  output logic             last_rnd_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IN_W-1:0]  in_q;
  logic [RND_W-1:0] rnd_q;

  assign load_o     = start_i & ~busy_q;
  assign first_in_o = in_q == '0;
  assign last_in_o  = in_q == IN_W'(INNER - 1);
  assign last_rnd_o = rnd_q == RND_W'(OUTER - 1);
  assign rnd_o      = rnd_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      in_q   <= '0;
      rnd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        in_q   <= '0;
        rnd_q  <= '0;
      end else if (busy_q) begin
        if (last_in_o) begin
          in_q <= '0;
          if (last_rnd_o) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end else begin
          in_q <= in_q + 1'b1;
        end
      end
    end
  end

  a_r2_busy_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_q);
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r4_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  a_r3_inner_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_q < IN_W'(INNER));
  a_r8_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !(last_in_o && last_rnd_o) |=> busy_q);
endmodule

// File: rtl/nfeistel_enc.sv
module nfeistel_enc
  import nf_pkg::*;
#(
  parameter int          OUTER    = 18,
  parameter int          INNER    = 6,
  parameter logic [63:0] SBOX_TBL = SBOX_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] pt_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [BLK_W-1:0] ct_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int RND_W = $clog2(OUTER + 1);

  logic             load_w, first_in_w, last_in_w, last_rnd_w;
  logic [RND_W-1:0] rnd_w;
  logic [RK_W-1:0]  rk_w;

  nf_ctrl #(.OUTER(OUTER), .INNER(INNER)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .load_o     (load_w),
    .first_in_o (first_in_w),
    .last_in_o  (last_in_w),
    .last_rnd_o (last_rnd_w),
    .rnd_o      (rnd_w),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  nf_key_sched #(.RND_W(RND_W)) i_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .key_i  (key_i),
    .adv_i  (busy_o & last_in_w),
    .rnd_i  (rnd_w),
    .rk_o   (rk_w)
  );

  logic [BLK_W-1:0] st_q, st_nx;
  logic [BR_W-1:0]  br [4];
  logic [BR_W-1:0]  f_q [N_LANE];
  logic [BR_W-1:0]  f_in [N_LANE];
  logic [BR_W-1:0]  f_nx [N_LANE];
  logic [BR_W-1:0]  mix [N_LANE];

  for (genvar b = 0; b < 4; b++) begin : g_br
    assign br[b] = st_q[BLK_W-1-b*BR_W -: BR_W];
  end

  // lane 0 works on branches 0/1 with KH, lane 1 on branches 2/3 with KL
  for (genvar ln = 0; ln < N_LANE; ln++) begin : g_lane
    assign f_in[ln] = first_in_w ? br[2*ln] : f_q[ln];

    nf_inner_round #(.SBOX_TBL(SBOX_TBL)) i_round (
      .x_i (f_in[ln]),
      .y_o (f_nx[ln])
    );

    assign mix[ln] = br[2*ln+1] ^ f_nx[ln] ^ rk_w[RK_W-1-ln*BR_W -: BR_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     f_q[ln] <= '0;
      else if (busy_o) f_q[ln] <= f_nx[ln];
    end
  end

  assign st_nx = last_rnd_w ? {br[0], mix[0], br[2], mix[1]}
                            : {mix[0], br[2], mix[1], br[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    st_q <= '0;
    else if (load_w)                st_q <= pt_i;
    else if (busy_o && last_in_w)   st_q <= st_nx;
  end

  assign ct_o = st_q;

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(ct_o));
  a_r5_state_frozen_mid_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_in_w && !start_i |=> $stable(ct_o));
endmodule

// File: tb/test_nfeistel_enc.sv
module test_nfeistel_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] pt = '0;
  logic [79:0] key = '0;
  logic [63:0] ct;
  logic        done, busy;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nfeistel_enc i_nfeistel_enc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pt_i(pt), .key_i(key),
    .ct_o(ct), .done_o(done), .busy_o(busy)
  );

  localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                     4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  function automatic logic [15:0] ref_f(logic [15:0] x);
    logic [7:0] l, r;
    for (int i = 0; i < 6; i++) begin
      l = x[15:8];
      r = x[7:0];
      x = {r, l ^ {SB[r[7:4]], SB[r[3:0]]}};
    end
    return x;
  endfunction

  function automatic logic [63:0] ref_enc(logic [63:0] p, logic [79:0] k);
    logic [15:0] b0, b1, b2, b3, n1, n3;
    logic [31:0] rk;
    for (int r = 0; r < 18; r++) begin
      {b0, b1, b2, b3} = p;
      rk = k[79:48] ^ 32'(r);
      n1 = b1 ^ ref_f(b0) ^ rk[31:16];
      n3 = b3 ^ ref_f(b2) ^ rk[15:0];
      p  = (r == 17) ? {b0, n1, b2, n3} : {n1, b2, n3, b0};
      k  = {k[47:0], k[79:48]};
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inject: raise a foreign start mid-run
  task automatic run_enc(input logic [63:0] p, input logic [79:0] k, input bit inject,
                         input string tag);
    int cyc;
    logic [63:0] exp;
    exp = ref_enc(p, k);
    @(negedge clk);
    start = 1'b1; pt = p; key = k;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 40) begin
        start = 1'b1; pt = ~p; key = ~k;
      end
      if (inject && cyc == 41) start = 1'b0;
    end
    check(cyc == 108, inject ? "R3 R8 latency" : "R3 latency", 64'(cyc), 64'd108);
    check(ct === exp, tag, ct, exp);
    check(busy === 1'b0, "R4 idle at done", 64'(busy), 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R4 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    int unused;
    unused = $urandom(32'd715);
    #1;
    check(done === 1'b0 && busy === 1'b0, "R1 flags at reset", {done, busy}, 64'd0);
    check(ct === 64'd0, "R1 ct at reset", ct, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    run_enc(64'd0, 80'd0, 1'b0, "R5 R6 R9 R11 zero vector");
    run_enc({64{1'b1}}, {80{1'b1}}, 1'b0, "R5 R6 R9 R11 ones vector");
    run_enc(64'h0123456789ABCDEF, 80'd0, 1'b0, "R5 R9 pattern pt");
    run_enc(64'h0123456789ABCDEF, 80'h0001_0002_0003_0004_0005, 1'b0, "R7 key words");
    run_enc(64'h0123456789ABCDEF, 80'h8000_0000_0000_0000_0001, 1'b0, "R7 key edges");

    held = ct;
    repeat (7) @(negedge clk);
    check(ct === held, "R10 hold while idle", ct, held);
    check(done === 1'b0, "R10 no spurious done", 64'(done), 64'd0);

    run_enc(64'hDEADBEEF_CAFEF00D, 80'h1234_5678_9ABC_DEF0_1357, 1'b1,
            "R8 result unaffected by start");

    for (int i = 0; i < 8; i++) begin
      logic [63:0] rp;
      logic [79:0] rk;
      rp = {$urandom, $urandom};
      rk = {16'($urandom), $urandom, $urandom};
      run_enc(rp, rk, (i % 3) == 0, "R5 R6 R7 R9 random vector");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule